// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a bus-attached watchdog. Software talks to it through three 32-bit registers: a control/status word, a command/count word and a timeout limit. The configuration is normally locked. Software opens it for a short time by writing an unlock key pair to the command word, and it keeps the counter from expiring by writing a separate service key pair to the same word. Each key is either two 16-bit halves in sequence or, when the wide-command bit is set, one 32-bit word.

Once enabled, the counter advances at a slow tick taken from the bus clock. When it reaches the programmed limit, the block raises its reset output for a fixed number of bus clocks and then restarts from zero. A bad second key half, or a configuration write while the block is locked and further updates are forbidden, raises the same reset pulse at once. Two status bits in the control word show that the lock is open and that the last configuration write has taken effect.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset the control word (offset 0x0) reads with the update-allowed bit 5 set and bits 13 (wide command), 11 (open), 10 (applied) and 7 (run) clear. The limit register (offset 0x8) reads DEF_TOVAL and the count (offset 0x4) reads 0.
- R2: In narrow mode (bit 13 = 0), writing 0xC520 and then 0xD928 to offset 0x4 opens the lock. After that write, bit 11 reads 1 and bit 10 reads 0.
- R3: In wide mode (bit 13 = 1), the single word 0xD928C520 opens the lock and the word 0xB480A602 clears the count. A lone half-key write has no effect.
- R4: While the lock is open, a write to offset 0x0 or 0x8 takes effect on the next clock and sets bit 10. A write to offset 0x0 also closes the lock.
- R5: An open lock that receives no control-word write closes by itself exactly UNLK_WIN clocks after the unlock write.
- R6: While the lock is closed and bit 5 is 1, writes to offsets 0x0 and 0x8 are ignored.
- R7: While the lock is closed and bit 5 is 0, a write to offset 0x0 or 0x8 raises the reset output on the next clock.
- R8: In narrow mode, if the first half of a key (0xC520 or 0xA602) is followed by a command write that is not its matching second half, the reset output rises on the next clock.
- R9: In narrow mode, 0xA602 followed by 0xB480 clears the count. A read of offset 0x4 returns the current count.
- R10: When bit 7 is 1, the count rises by one every TICK_DIV clocks. When bit 7 is 0, the count holds.
- R11: With bit 7 set and the count restarted from zero, the reset output rises TOVAL*TICK_DIV+1 clocks later. It stays high for RST_LEN clocks, after which the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: 0x0 control, 0x4 command/count, 0x8 limit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| wdog_rst | output | 1 | Reset request pulse |

## Verification
The bench goes after the points where the key checker and the lock window meet the counter. One is the exact cycle at which the timeout pulse starts, and its width; a design off by one in the tick divider or the compare would start the pulse early or late, or stretch it. Others are the last open cycle of the unlock window, a half key written in wide mode, and a wrong second half in narrow mode; a design that got these wrong would leave the lock open too long, accept a partial key, or miss the immediate reset. A locked write is tried with updates both allowed and forbidden; a design that mixed these up would either change the limit silently or never raise the reset.

// File: rtl/kgw_pkg.sv
`timescale 1ns/1ps
package kgw_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    // key halves, lower half written first in narrow mode
    localparam logic [15:0] UNL_LO = 16'hC520;
    localparam logic [15:0] UNL_HI = 16'hD928;
    localparam logic [15:0] SVC_LO = 16'hA602;
    localparam logic [15:0] SVC_HI = 16'hB480;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_LIM  = 4'h8;

    // control word bit positions (software decodes these)
    localparam int B_WIDE  = 13;
    localparam int B_OPEN  = 11;
    localparam int B_APPL  = 10;
    localparam int B_CLKLO = 8;
    localparam int B_RUN   = 7;
    localparam int B_UPD   = 5;
    localparam int B_WAIT  = 1;
    localparam int B_HALT  = 0;

    typedef struct packed {
        logic       wide;
        logic [1:0] clksel;
        logic       run;
        logic       upd;
        logic       wait_en;
        logic       halt_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{wide: 1'b0, clksel: 2'b00, run: 1'b0,
                                     upd: 1'b1, wait_en: 1'b0, halt_en: 1'b0};

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_UNL_HALF,
        KS_SVC_HALF
    } key_state_e;

    typedef struct packed {
        logic unlock;
        logic service;
        logic bad;
    } key_ev_t;

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c, input logic open_s,
                                                    input logic appl_s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_WIDE]              = c.wide;
        w[B_OPEN]              = open_s;
        w[B_APPL]              = appl_s;
        w[B_CLKLO+1:B_CLKLO]   = c.clksel;
        w[B_RUN]               = c.run;
        w[B_UPD]               = c.upd;
        w[B_WAIT]              = c.wait_en;
        w[B_HALT]              = c.halt_en;
        return w;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.wide    = w[B_WIDE];
        c.clksel  = w[B_CLKLO+1:B_CLKLO];
        c.run     = w[B_RUN];
        c.upd     = w[B_UPD];
        c.wait_en = w[B_WAIT];
        c.halt_en = w[B_HALT];
        return c;
    endfunction

endpackage

// File: rtl/kgw_keyseq.sv
`timescale 1ns/1ps
module kgw_keyseq
    import kgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wide,
    output key_ev_t           ev
);

    key_state_e state, state_nx;
    logic [15:0] lo;

    assign lo = wdata[15:0];

    always_comb begin
        ev       = '0;
        state_nx = state;
        if (cmd_wr) begin
            if (wide) begin
                state_nx = KS_IDLE;
                if (wdata == {UNL_HI, UNL_LO}) begin
                    ev.unlock = 1'b1;
                end else if (wdata == {SVC_HI, SVC_LO}) begin
                    ev.service = 1'b1;
                end
            end else begin
                case (state)
                    KS_IDLE: begin
                        if (lo == UNL_LO) begin
                            state_nx = KS_UNL_HALF;
                        end else if (lo == SVC_LO) begin
                            state_nx = KS_SVC_HALF;
                        end
                    end
                    KS_UNL_HALF: begin
                        state_nx = KS_IDLE;
                        if (lo == UNL_HI) ev.unlock = 1'b1;
                        else              ev.bad    = 1'b1;
                    end
                    KS_SVC_HALF: begin
                        state_nx = KS_IDLE;
                        if (lo == SVC_HI) ev.service = 1'b1;
                        else              ev.bad     = 1'b1;
                    end
                    default: state_nx = KS_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= KS_IDLE;
        else     state <= state_nx;
    end

endmodule

// File: rtl/kgw_regs.sv
`timescale 1ns/1ps
module kgw_regs
    import kgw_pkg::*;
#(
    parameter int CNT_W     = 17,
    parameter int UNLK_WIN  = 128,
    parameter int DEF_TOVAL = 60000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unlock,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  toval,
    output logic              open_s,
    output logic              appl_s,
    output logic              cfg_err
);

    localparam int WIN_W = (UNLK_WIN > 1) ? $clog2(UNLK_WIN) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(UNLK_WIN - 1);

    logic [WIN_W-1:0] win;
    logic cfg_wr, apply;

    assign cfg_wr  = wr && ((addr == OFS_CTRL) || (addr == OFS_LIM));
    assign apply   = cfg_wr && open_s;
    assign cfg_err = cfg_wr && !open_s && !ctrl.upd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_RESET;
            toval  <= CNT_W'(DEF_TOVAL);
            open_s <= 1'b0;
            appl_s <= 1'b0;
            win    <= '0;
        end else begin
            if (unlock) begin
                open_s <= 1'b1;
                appl_s <= 1'b0;
                win    <= '0;
            end else if (open_s) begin
                win <= win + 1'b1;
                if ((apply && addr == OFS_CTRL) || win == WIN_LAST) begin
                    open_s <= 1'b0;
                end
            end
            if (apply) begin
                appl_s <= 1'b1;
                if (addr == OFS_CTRL) ctrl  <= ctrl_unpack(wdata);
                else                  toval <= wdata[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/kgw_timer.sv
`timescale 1ns/1ps
module kgw_timer #(
    parameter int CNT_W    = 17,
    parameter int TICK_DIV = 32000,
    parameter int RST_LEN  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] toval,
    input  logic             service,
    input  logic             fire_now,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req
);

    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int LEN_W = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [LEN_W-1:0] LEN_LAST = LEN_W'(RST_LEN - 1);

    logic [PRE_W-1:0] pre;
    logic [LEN_W-1:0] plen;
    logic busy, tick, expire, start;

    assign tick    = run && !busy && (pre == PRE_LAST);
    assign expire  = run && !busy && (cnt >= toval);
    assign start   = !busy && (expire || fire_now);
    assign rst_req = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre  <= '0;
            plen <= '0;
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            if (busy) begin
                plen <= plen + 1'b1;
                if (plen == LEN_LAST) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                    pre  <= '0;
                end
            end else begin
                if (start) begin
                    busy <= 1'b1;
                    plen <= '0;
                end
                if (!run) begin
                    pre <= '0;
                end else if (tick) begin
                    pre <= '0;
                    cnt <= cnt + 1'b1;
                end else begin
                    pre <= pre + 1'b1;
                end
            end
            if (service) begin
                cnt <= '0;
                pre <= '0;
            end
        end
    end

endmodule

// File: rtl/keyguard_wdt.sv
`timescale 1ns/1ps
module keyguard_wdt
    import kgw_pkg::*;
#(
    parameter int CNT_W     = 17,
    parameter int TICK_DIV  = 32000,
    parameter int RST_LEN   = 16,
    parameter int UNLK_WIN  = 128,
    parameter int DEF_TOVAL = 60000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdog_rst
);

    logic             wr, cmd_wr, cfg_err, open_s, appl_s;
    key_ev_t          kev;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] toval, cnt;

    assign wr     = bus_sel && bus_wr;
    assign cmd_wr = wr && (bus_addr == OFS_CMD);

    kgw_keyseq u_keys (
        .clk    (clk),
        .rst    (rst),
        .cmd_wr (cmd_wr),
        .wdata  (bus_wdata),
        .wide   (ctrl.wide),
        .ev     (kev)
    );

    kgw_regs #(
        .CNT_W     (CNT_W),
        .UNLK_WIN  (UNLK_WIN),
        .DEF_TOVAL (DEF_TOVAL)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .unlock  (kev.unlock),
        .ctrl    (ctrl),
        .toval   (toval),
        .open_s  (open_s),
        .appl_s  (appl_s),
        .cfg_err (cfg_err)
    );

    kgw_timer #(
        .CNT_W    (CNT_W),
        .TICK_DIV (TICK_DIV),
        .RST_LEN  (RST_LEN)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .toval    (toval),
        .service  (kev.service),
        .fire_now (kev.bad || cfg_err),
        .cnt      (cnt),
        .rst_req  (wdog_rst)
    );

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = ctrl_pack(ctrl, open_s, appl_s);
            OFS_CMD:  bus_rdata = DATA_W'(cnt);
            OFS_LIM:  bus_rdata = DATA_W'(toval);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kgw_checker.sv
`timescale 1ns/1ps
module kgw_checker
    import kgw_pkg::*;
#(
    parameter int CNT_W    = 17,
    parameter int UNLK_WIN = 128,
    parameter int RST_LEN  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wdog_rst,
    input logic              open_s,
    input logic              upd,
    input logic              run,
    input logic              unlock_ev,
    input logic              service_ev,
    input logic              bad_ev,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  toval
);

    int hi_len;
    int open_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len   <= 0;
            open_len <= 0;
        end else begin
            hi_len   <= wdog_rst ? hi_len + 1 : 0;
            open_len <= (open_s && !unlock_ev) ? open_len + 1 : 0;
        end
    end

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
        unlock_ev |=> open_s); // R2

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        open_s |-> open_len < UNLK_WIN); // R5

    AST_LOCKED_LIMIT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == OFS_LIM && !open_s && upd) |=> $stable(toval)); // R6

    AST_BAD_KEY_RESET: assert property (@(posedge clk) disable iff (rst)
        bad_ev |=> wdog_rst); // R8

    AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        service_ev |=> cnt == '0); // R9

    AST_HALTED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(cnt) || cnt == '0)); // R10

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |-> hi_len < RST_LEN); // R11

endmodule

bind keyguard_wdt kgw_checker #(
    .CNT_W    (CNT_W),
    .UNLK_WIN (UNLK_WIN),
    .RST_LEN  (RST_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wdog_rst   (wdog_rst),
    .open_s     (open_s),
    .upd        (ctrl.upd),
    .run        (ctrl.run),
    .unlock_ev  (kev.unlock),
    .service_ev (kev.service),
    .bad_ev     (kev.bad),
    .cnt        (cnt),
    .toval      (toval)
);

// File: tb/sim_keyguard_wdt.sv
`timescale 1ns/1ps
module sim_keyguard_wdt;

    localparam int TDIV  = 4;
    localparam int RLEN  = 16;
    localparam int WIN   = 128;
    localparam int DEFTO = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_rst;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    keyguard_wdt #(
        .CNT_W     (17),
        .TICK_DIV  (TDIV),
        .RST_LEN   (RLEN),
        .UNLK_WIN  (WIN),
        .DEF_TOVAL (DEFTO)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdog_rst  (wdog_rst)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] mask;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'h0, 32'h0000_0020, 32'h0000_2CA0, 4'd1},  // R1 control word
        '{1'b0, 4'h8, 32'd1000,      32'hFFFF_FFFF, 4'd1},  // R1 limit
        '{1'b0, 4'h4, 32'h0,         32'hFFFF_FFFF, 4'd1},  // R1 count
        '{1'b1, 4'h8, 32'd5,         32'h0,         4'd6},  // R6 locked write
        '{1'b0, 4'h8, 32'd1000,      32'hFFFF_FFFF, 4'd6},  // R6 limit kept
        '{1'b1, 4'h4, 32'h0000_C520, 32'h0,         4'd2},  // R2 first half
        '{1'b1, 4'h4, 32'h0000_D928, 32'h0,         4'd2},  // R2 second half
        '{1'b0, 4'h0, 32'h0000_0800, 32'h0000_0C00, 4'd2},  // R2 open, not applied
        '{1'b1, 4'h8, 32'd6,         32'h0,         4'd4},  // R4 limit write
        '{1'b0, 4'h0, 32'h0000_0C00, 32'h0000_0C00, 4'd4},  // R4 applied, still open
        '{1'b0, 4'h8, 32'd6,         32'hFFFF_FFFF, 4'd4},  // R4 limit taken
        '{1'b1, 4'h0, 32'h0000_20A0, 32'h0,         4'd4},  // R4 wide+run+upd
        '{1'b0, 4'h0, 32'h0000_24A0, 32'h0000_2CA0, 4'd4}   // R4 closed after control write
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic cycles_to_rise(output int n);
        n = 0;
        while (!wdog_rst && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_width(output int m);
        m = 0;
        while (wdog_rst && m < 500) begin
            m++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd, rd2;
        int n, m;

        wait_cycles(4);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset output", {31'b0, wdog_rst}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), rd & VECS[i].mask, VECS[i].data);
            end
        end

        // R3: wide service word clears count; then R11 timing from zero
        bus_write(4'h4, 32'hB480_A602);
        bus_read(4'h4, rd);
        check("R3 wide service", rd, 32'h0);
        cycles_to_rise(n);
        check("R11 rise delay", n, 6 * TDIV + 1);
        pulse_width(m);
        check("R11 pulse width", m, RLEN);
        bus_read(4'h4, rd);
        check("R11 count cleared", rd, 32'h0);

        // R3: half key in wide mode ignored
        bus_write(4'h4, 32'h0000_C520);
        bus_read(4'h0, rd);
        check("R3 half key ignored", rd & 32'h800, 32'h0);

        // R3: wide unlock word
        bus_write(4'h4, 32'hD928_C520);
        bus_read(4'h0, rd);
        check("R3 wide unlock", rd & 32'h800, 32'h800);
        bus_write(4'h0, 32'h0000_00A0);
        wait_cycles(6);
        bus_read(4'h4, rd);
        check("R10 count advances", rd, 32'd3);

        // R9: narrow service pair
        bus_write(4'h4, 32'h0000_A602);
        bus_write(4'h4, 32'h0000_B480);
        bus_read(4'h4, rd);
        check("R9 narrow service", rd, 32'h0);

        // R8: wrong second half
        bus_write(4'h4, 32'h0000_A602);
        bus_write(4'h4, 32'h0000_1234);
        check("R8 bad half reset", {31'b0, wdog_rst}, 32'h1);
        pulse_width(m);

        // R5: window expiry after narrow unlock
        bus_write(4'h4, 32'h0000_C520);
        bus_write(4'h4, 32'h0000_D928);
        bus_read(4'h0, rd);
        check("R2 narrow unlock", rd & 32'hC00, 32'h800);
        wait_cycles(WIN - 1);
        bus_read(4'h0, rd);
        check("R5 last open cycle", rd & 32'h800, 32'h800);
        wait_cycles(1);
        bus_read(4'h0, rd);
        check("R5 closed", rd & 32'h800, 32'h0);
        bus_write(4'h8, 32'd9);
        bus_read(4'h8, rd);
        check("R6 locked limit kept", rd, 32'd6);

        // R10 halt and R7 forbidden update
        bus_write(4'h4, 32'h0000_C520);
        bus_write(4'h4, 32'h0000_D928);
        bus_write(4'h0, 32'h0000_0000);
        wait_cycles(20);
        check("R7 quiet before", {31'b0, wdog_rst}, 32'h0);
        bus_read(4'h4, rd);
        wait_cycles(20);
        bus_read(4'h4, rd2);
        check("R10 halted count holds", rd2, rd);
        bus_write(4'h8, 32'd7);
        check("R7 locked write resets", {31'b0, wdog_rst}, 32'h1);
        pulse_width(m);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule